// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block watches a parallel input port, organised as one or more banks of equal width, and raises an interrupt when an enabled pin departs from its reference. Each pin picks its reference. It is either the pin's own value one clock earlier (change detection) or a programmed default bit (compare-to-default, used for level-high or level-low sensing). When a bank fires, it takes a snapshot of its whole port into a capture register. It also marks one cause bit in its flag register and then stays pending until the host performs the clearing read.

Raw pins pass through a two-flop synchroniser before any comparison. The register interface supplies the per-pin enable, mode and default vectors, a shared configuration byte, and one-cycle read strobes for each bank's port and capture registers. The block returns the synchronised port value, the flag and capture registers, and one interrupt pin per bank. Each interrupt pin is given as a drive level plus an output enable, so push-pull or open-drain drive can be built at the pad. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `gpio_ioc_ctrl`

## Requirements
- R1: After reset, all flag and capture bits are 0, no bank is pending, and with configuration 0x00 each interrupt pin drives level 1 with output enable 1 (inactive, active-low, push-pull).
- R2: A pin whose enable bit is 0 never makes its bank pending, whatever its value, mode or default bit.
- R3: With mode bit 0, an enabled pin fires when its synchronised value differs from the previous clock's synchronised value. The flag appears at the third rising clock edge after the raw pin changes.
- R4: With mode bit 1, an enabled pin fires while its synchronised value differs from its default bit. If the mismatch persists, the bank becomes pending again on the clock edge after a clearing read.
- R5: On firing, the bank's capture register loads the bank's synchronised port value. The flag register sets exactly one bit, which is the lowest-index firing pin when several fire in the same cycle.
- R6: While a bank is pending, its flag and capture registers hold their values and further pin activity is ignored.
- R7: Configuration bit 0 selects the clearing read: 0 means a port read of the bank, 1 means a capture read. The other read has no effect. A clear zeroes the flag register and leaves the capture register unchanged.
- R8: Configuration bit 1 sets push-pull polarity: 1 drives level 1 when active and 0 when inactive, while 0 does the opposite. The output enable stays 1.
- R9: Configuration bit 2 selects open-drain: the level is always 0 and the output enable equals the active state, whatever bit 1 holds.
- R10: Configuration bit 6 makes every bank's interrupt pin active when any bank is pending.
- R11: Banks are independent. Each bank has its own pending state, flag, capture and read strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | BANK_W*N_BANKS | Raw port pins, bank b in bits [b*BANK_W +: BANK_W] |
| int_en | input | BANK_W*N_BANKS | Per-pin interrupt enable |
| int_mode | input | BANK_W*N_BANKS | Per-pin mode: 0 change, 1 compare-to-default |
| int_dflt | input | BANK_W*N_BANKS | Per-pin default bit for compare mode |
| cfg | input | 8 | Configuration: bit0 clear select, bit1 polarity, bit2 open-drain, bit6 mirror |
| rd_port | input | N_BANKS | One-cycle strobe: host reads bank port register |
| rd_cap | input | N_BANKS | One-cycle strobe: host reads bank capture register |
| port_val | output | BANK_W*N_BANKS | Synchronised port value |
| int_flag | output | BANK_W*N_BANKS | Flag registers, one bit set per pending bank |
| int_cap | output | BANK_W*N_BANKS | Capture registers |
| irq_lvl | output | N_BANKS | Interrupt pin drive level per bank |
| irq_oe | output | N_BANKS | Interrupt pin output enable per bank |

## Verification
Some properties are checked on every cycle. A pending bank holds exactly one flag bit. Flag and capture stay frozen while pending. The selected read always clears, and the unselected read never clears. With nothing to report, a bank never goes pending. With mirroring on, all interrupt pins agree. Other behaviour needs the bench's scenarios to show it. These are the three-cycle latency, the lowest-index choice among simultaneous causes, and the exact captured value. They also include re-assertion in compare-to-default mode right after a clear, disabled pins being ignored, and the level and enable seen on the pins under each polarity, drive and mirror setting.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int CFG_W          = 8;
  localparam int CFG_CLR_SEL    = 0;
  localparam int CFG_POL_HI     = 1;
  localparam int CFG_OPEN_DRAIN = 2;
  localparam int CFG_MIRROR     = 6;

  typedef struct packed {
    logic lvl;
    logic oe;
  } irq_drive_t;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_ioc_cmp.sv
module gpio_ioc_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] dflt,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic ref_bit;
    assign ref_bit = mode[i] ? dflt[i] : prev_q[i];
    assign hit[i]  = en[i] & (pin_s[i] ^ ref_bit);
  end
endmodule

// File: rtl/gpio_ioc_bank.sv
module gpio_ioc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] hit,
  input  logic         clr,
  output logic         pending,
  output logic [W-1:0] flag,
  output logic [W-1:0] cap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] first_hit;
  logic         fire;

  assign first_hit = hit & (~hit + ONE);
  assign fire      = !pending && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      flag    <= '0;
      cap     <= '0;
    end else if (pending && clr) begin
      pending <= 1'b0;
      flag    <= '0;
    end else if (fire) begin
      pending <= 1'b1;
      flag    <= first_hit;
      cap     <= pin_s;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ($countones(flag) == 1)); // R5
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (flag == '0)); // R7
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> (pending && $stable(flag) && $stable(cap))); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clr) |=> (!pending && $stable(cap))); // R7
  AST_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && hit == '0) |=> !pending); // R2
endmodule

// File: rtl/gpio_ioc_drv.sv
module gpio_ioc_drv
  import gpio_ioc_pkg::*;
(
  input  logic       act,
  input  logic       pol_hi,
  input  logic       open_drain,
  output irq_drive_t drv
);
  always_comb begin
    if (open_drain) begin
      drv.lvl = 1'b0;
      drv.oe  = act;
    end else begin
      drv.lvl = pol_hi ? act : !act;
      drv.oe  = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
  import gpio_ioc_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int N_BANKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W*N_BANKS-1:0] pin_in,
  input  logic [BANK_W*N_BANKS-1:0] int_en,
  input  logic [BANK_W*N_BANKS-1:0] int_mode,
  input  logic [BANK_W*N_BANKS-1:0] int_dflt,
  input  logic [7:0]                cfg,
  input  logic [N_BANKS-1:0]        rd_port,
  input  logic [N_BANKS-1:0]        rd_cap,
  output logic [BANK_W*N_BANKS-1:0] port_val,
  output logic [BANK_W*N_BANKS-1:0] int_flag,
  output logic [BANK_W*N_BANKS-1:0] int_cap,
  output logic [N_BANKS-1:0]        irq_lvl,
  output logic [N_BANKS-1:0]        irq_oe
);
  localparam int PW = BANK_W * N_BANKS;

  logic [PW-1:0]      pin_s;
  logic [PW-1:0]      hit;
  logic [N_BANKS-1:0] pend;
  logic [N_BANKS-1:0] clr;
  logic [N_BANKS-1:0] act;

  gpio_ioc_sync #(.W(PW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pin_s)
  );

  assign port_val = pin_s;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    irq_drive_t drv;

    gpio_ioc_cmp #(.W(BANK_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pin_s[b*BANK_W +: BANK_W]),
      .en    (int_en[b*BANK_W +: BANK_W]),
      .mode  (int_mode[b*BANK_W +: BANK_W]),
      .dflt  (int_dflt[b*BANK_W +: BANK_W]),
      .hit   (hit[b*BANK_W +: BANK_W])
    );

    assign clr[b] = cfg[CFG_CLR_SEL] ? rd_cap[b] : rd_port[b];

    gpio_ioc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s[b*BANK_W +: BANK_W]),
      .hit     (hit[b*BANK_W +: BANK_W]),
      .clr     (clr[b]),
      .pending (pend[b]),
      .flag    (int_flag[b*BANK_W +: BANK_W]),
      .cap     (int_cap[b*BANK_W +: BANK_W])
    );

    assign act[b] = cfg[CFG_MIRROR] ? (|pend) : pend[b];

    gpio_ioc_drv u_drv (
      .act        (act[b]),
      .pol_hi     (cfg[CFG_POL_HI]),
      .open_drain (cfg[CFG_OPEN_DRAIN]),
      .drv        (drv)
    );

    assign irq_lvl[b] = drv.lvl;
    assign irq_oe[b]  = drv.oe;

    AST_WRONG_READ_PORTSEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[b] && !cfg[CFG_CLR_SEL] && !rd_port[b]) |=> pend[b]); // R7
    AST_WRONG_READ_CAPSEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[b] && cfg[CFG_CLR_SEL] && !rd_cap[b]) |=> pend[b]); // R7
  end

  AST_MIRROR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[CFG_MIRROR] |-> ((irq_lvl == {N_BANKS{irq_lvl[0]}}) &&
                         (irq_oe == {N_BANKS{irq_oe[0]}}))); // R10
  AST_PUSHPULL_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[CFG_OPEN_DRAIN] |-> (irq_oe == '1)); // R8
endmodule

// File: tb/gpio_ioc_ctrl_test.sv
module gpio_ioc_ctrl_test;
  localparam int BW = 8;
  localparam int NB = 2;
  localparam int PW = BW * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] pin_in = '0;
  logic [PW-1:0] int_en = '0;
  logic [PW-1:0] int_mode = '0;
  logic [PW-1:0] int_dflt = '0;
  logic [7:0]    cfg = 8'h00;
  logic [NB-1:0] rd_port = '0;
  logic [NB-1:0] rd_cap = '0;
  logic [PW-1:0] port_val, int_flag, int_cap;
  logic [NB-1:0] irq_lvl, irq_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_ioc_ctrl #(.BANK_W(BW), .N_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .int_en(int_en),
    .int_mode(int_mode), .int_dflt(int_dflt), .cfg(cfg),
    .rd_port(rd_port), .rd_cap(rd_cap), .port_val(port_val),
    .int_flag(int_flag), .int_cap(int_cap), .irq_lvl(irq_lvl), .irq_oe(irq_oe)
  );

  typedef struct {
    string         tag;
    logic [PW-1:0] flag;
    logic [PW-1:0] cap;
    logic [NB-1:0] lvl;
    logic [NB-1:0] oe;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [PW-1:0] f,
                            input logic [PW-1:0] c, input logic [NB-1:0] l,
                            input logic [NB-1:0] o);
    exp_t e;
    e.tag = tag; e.flag = f; e.cap = c; e.lvl = l; e.oe = o;
    exp_q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic pulse_port(input int b);
    rd_port[b] = 1'b1; tick(1); rd_port[b] = 1'b0;
  endtask

  task automatic pulse_cap(input int b);
    rd_cap[b] = 1'b1; tick(1); rd_cap[b] = 1'b0;
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "flag", int_flag, e.flag);
        cmp(e.tag, "cap", int_cap, e.cap);
        cmp(e.tag, "lvl", {{(PW-NB){1'b0}}, irq_lvl}, {{(PW-NB){1'b0}}, e.lvl});
        cmp(e.tag, "oe", {{(PW-NB){1'b0}}, irq_oe}, {{(PW-NB){1'b0}}, e.oe});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    expect_out("R1 reset", 16'h0000, 16'h0000, 2'b11, 2'b11);

    // R2: disabled pin toggles
    pin_in = 16'h0008; tick(3);
    expect_out("R2 disabled pin", 16'h0000, 16'h0000, 2'b11, 2'b11);
    int_en = 16'h00FF; tick(3);
    expect_out("R2 enable with no change", 16'h0000, 16'h0000, 2'b11, 2'b11);

    // R3 / R5: two pins change together, lowest index wins
    pin_in = 16'h002C; tick(3);
    expect_out("R3 R5 change fires", 16'h0004, 16'h002C, 2'b10, 2'b11);

    // R6: activity while pending ignored
    pin_in = 16'h00AC; tick(3);
    expect_out("R6 hold while pending", 16'h0004, 16'h002C, 2'b10, 2'b11);

    // R7: clear by port read (cfg bit0 = 0)
    pulse_cap(0);
    expect_out("R7 capture read ignored", 16'h0004, 16'h002C, 2'b10, 2'b11);
    pulse_port(0);
    expect_out("R7 port read clears", 16'h0000, 16'h002C, 2'b11, 2'b11);

    // R7: clear by capture read (cfg bit0 = 1)
    cfg = 8'h01;
    pin_in = 16'h00AD; tick(3);
    expect_out("R3 single bit fires", 16'h0001, 16'h00AD, 2'b10, 2'b11);
    pulse_port(0);
    expect_out("R7 port read ignored", 16'h0001, 16'h00AD, 2'b10, 2'b11);
    pulse_cap(0);
    expect_out("R7 capture read clears", 16'h0000, 16'h00AD, 2'b11, 2'b11);

    // R4: bank1 pin0 level-high (mode 1, default 0)
    int_en[8] = 1'b1; int_mode[8] = 1'b1; int_dflt[8] = 1'b0;
    pin_in = 16'h01AD; tick(3);
    expect_out("R4 R11 default mode fires", 16'h0100, 16'h01AD, 2'b01, 2'b11);
    pulse_cap(1);
    expect_out("R4 cleared", 16'h0000, 16'h01AD, 2'b11, 2'b11);
    tick(1);
    expect_out("R4 reasserts", 16'h0100, 16'h01AD, 2'b01, 2'b11);
    pin_in = 16'h00AD; tick(3);
    pulse_cap(1); tick(2);
    expect_out("R4 stays clear on match", 16'h0000, 16'h01AD, 2'b11, 2'b11);

    // R2: disabled bank1 pins
    pin_in = 16'hFEAD; tick(3);
    expect_out("R2 disabled bank1 pins", 16'h0000, 16'h01AD, 2'b11, 2'b11);
    pin_in = 16'h00AD; tick(3);

    // R8: active-high push-pull
    cfg = 8'h03;
    pin_in = 16'h01AD; tick(3);
    expect_out("R8 active high", 16'h0100, 16'h01AD, 2'b10, 2'b11);

    // R9: open drain overrides polarity
    cfg = 8'h07; tick(1);
    expect_out("R9 open drain", 16'h0100, 16'h01AD, 2'b00, 2'b10);

    // R10: mirror
    cfg = 8'h43; tick(1);
    expect_out("R10 mirror push-pull", 16'h0100, 16'h01AD, 2'b11, 2'b11);
    cfg = 8'h47; tick(1);
    expect_out("R10 mirror open drain", 16'h0100, 16'h01AD, 2'b00, 2'b11);

    // R11: bank0 read does not clear bank1
    cfg = 8'h43;
    pulse_cap(0);
    expect_out("R11 other bank read", 16'h0100, 16'h01AD, 2'b11, 2'b11);
    pin_in = 16'h00AD; tick(3);
    pulse_cap(1); tick(2);
    expect_out("R11 own read clears", 16'h0000, 16'h01AD, 2'b00, 2'b11);

    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule